// File: doc/BRIEF.md
# Receive Idle Timeout and Line Break Detector

This block sits next to a serial receiver and watches two things: how long the receive FIFO has held data without a new character arriving, and how long the receive line has stayed low. It takes a one-cycle tick once per bit period, the synchronized receive line, the configured frame length, a FIFO not-empty flag and a pulse for each received character. From these it produces two outputs. The first is a timeout status level that tells software the FIFO holds data that is going stale. The second is a break event pulse that fires when the line has been held low for longer than a whole frame.

The timeout counter runs only while the mask input enables it, so the mask also acts as a power-saving enable. Software can clear the timeout with a strobe. Emptying the FIFO also clears it. The break comparison uses the full frame length in bit periods, which covers the start bit, the data bits, the parity bit and the stop bits. The length is clamped to a legal window before the comparison is made.

Top module: `uart_rx_watch`

## Requirements
- R1: With toMask=1, fifoNotEmpty=1, no charRcvd and no toClear, toStatus goes to 1 on the clock edge that samples the 32nd bitTick. It is visible in the following cycle. Cycles without bitTick do not count.
- R2: toStatus goes to 0 on the first clock edge that samples fifoNotEmpty=0 or toClear=1. The idle count restarts from zero at the same edge.
- R3: While toMask=0, toStatus is 0 from the next edge on and the idle count holds at zero. After toMask returns to 1, a full 32 further ticks are needed to set toStatus.
- R4: A charRcvd pulse restarts the idle count, so 32 new ticks are needed after it. A charRcvd pulse does not clear a toStatus that is already 1.
- R5: With an effective frame length L, breakPulse is 1 for exactly one cycle. That cycle follows the edge that samples the (L+1)th bitTick of a continuous low interval on rxLine.
- R6: breakPulse fires at most once per low interval. It re-arms only after rxLine has been sampled high.
- R7: The effective frame length is frameLen clamped to the range 7 to 12. A value below 7 acts as 7 and a value above 12 acts as 12.
- R8: A low interval of L ticks or fewer gives no pulse. A single sampled high cycle restarts the low count.
- R9: After reset, toStatus=0 and breakPulse=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe once per bit period |
| rxLine | input | 1 | Synchronized receive line, idle high |
| frameLen | input | FRAME_W | Frame length in bit periods, start to stop |
| fifoNotEmpty | input | 1 | Receive FIFO holds at least one character |
| charRcvd | input | 1 | One-cycle pulse per character received |
| toMask | input | 1 | Timeout enable; 0 stops the counter and blocks the status |
| toClear | input | 1 | Software clear strobe for the timeout status |
| toStatus | output | 1 | Receive timeout status level |
| breakPulse | output | 1 | One-cycle pulse when a line break is detected |

## Verification
On every cycle the assertions check these properties: the timeout status falls right after the mask drops, after the FIFO empties and after a clear strobe; it only rises on a bit tick; a break pulse lasts a single cycle and always follows a sampled low line. Some behaviour can only be shown by the bench's scenarios. This covers the exact tick on which the timeout and the break fire, the restart caused by a character arrival, the re-arming after the line goes high, and the clamping of out-of-range frame lengths.

// File: rtl/uart_rx_watch_pkg.sv
package uart_rx_watch_pkg;
  // strobes the control issues to the counter datapath
  typedef struct packed {
    logic idleClr;
    logic idleInc;
    logic lowClr;
    logic lowInc;
  } rxw_strobe_t;
endpackage

// File: rtl/uart_rx_watch_dpath.sv
module uart_rx_watch_dpath
  import uart_rx_watch_pkg::*;
#(
  parameter int IDLE_LIMIT = 32,
  parameter int FRAME_W    = 4,
  parameter int MIN_FRAME  = 7,
  parameter int MAX_FRAME  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxw_strobe_t        stb,
  input  logic [FRAME_W-1:0] frameLen,
  output logic               idleLast,
  output logic               lowOver
);
  localparam int IDLE_W  = $clog2(IDLE_LIMIT + 1);
  localparam int LOW_SAT = MAX_FRAME + 1;
  localparam int LOW_W   = $clog2(LOW_SAT + 1);
  localparam logic [IDLE_W-1:0]  IDLE_TOP  = IDLE_W'(IDLE_LIMIT);
  localparam logic [IDLE_W-1:0]  IDLE_PRE  = IDLE_W'(IDLE_LIMIT - 1);
  localparam logic [LOW_W-1:0]   LOW_TOP   = LOW_W'(LOW_SAT);
  localparam logic [FRAME_W-1:0] FRAME_MIN = FRAME_W'(MIN_FRAME);
  localparam logic [FRAME_W-1:0] FRAME_MAX = FRAME_W'(MAX_FRAME);

  logic [IDLE_W-1:0]  idleCnt;
  logic [LOW_W-1:0]   lowCnt;
  logic [FRAME_W-1:0] clampLen;
  logic [LOW_W-1:0]   effLen;

  // idle bit-period counter, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                idleCnt <= '0;
    else if (stb.idleClr)                     idleCnt <= '0;
    else if (stb.idleInc && idleCnt != IDLE_TOP) idleCnt <= idleCnt + 1'b1;
  end

  // low-level duration counter, saturating one past the longest frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               lowCnt <= '0;
    else if (stb.lowClr)                     lowCnt <= '0;
    else if (stb.lowInc && lowCnt != LOW_TOP) lowCnt <= lowCnt + 1'b1;
  end

  // keep the frame length inside the legal window
  always_comb begin
    if (frameLen < FRAME_MIN)      clampLen = FRAME_MIN;
    else if (frameLen > FRAME_MAX) clampLen = FRAME_MAX;
    else                           clampLen = frameLen;
  end

  assign effLen   = LOW_W'(clampLen);
  assign idleLast = (idleCnt == IDLE_PRE);
  assign lowOver  = (lowCnt >= effLen);
endmodule

// File: rtl/uart_rx_watch_ctrl.sv
module uart_rx_watch_ctrl
  import uart_rx_watch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitTick,
  input  logic        rxLine,
  input  logic        fifoNotEmpty,
  input  logic        charRcvd,
  input  logic        toMask,
  input  logic        toClear,
  input  logic        idleLast,
  input  logic        lowOver,
  output rxw_strobe_t stb,
  output logic        toStatus,
  output logic        breakPulse
);
  logic countEn;
  logic setTo;
  logic fire;
  logic armed;

  assign countEn = toMask && fifoNotEmpty;

  always_comb begin
    stb.idleClr = !countEn || charRcvd || toClear;
    stb.idleInc = bitTick;
    stb.lowClr  = rxLine;
    stb.lowInc  = bitTick && !rxLine;
  end

  assign setTo = countEn && bitTick && idleLast && !charRcvd && !toClear;
  assign fire  = bitTick && !rxLine && armed && lowOver;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    toStatus <= 1'b0;
    else if (!countEn || toClear) toStatus <= 1'b0;
    else if (setTo)               toStatus <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       armed <= 1'b1;
    else if (rxLine) armed <= 1'b1;
    else if (fire)   armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) breakPulse <= 1'b0;
    else       breakPulse <= fire;
  end
endmodule

// File: rtl/uart_rx_watch.sv
module uart_rx_watch
  import uart_rx_watch_pkg::*;
#(
  parameter int IDLE_LIMIT = 32,
  parameter int FRAME_W    = 4,
  parameter int MIN_FRAME  = 7,
  parameter int MAX_FRAME  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               rxLine,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               fifoNotEmpty,
  input  logic               charRcvd,
  input  logic               toMask,
  input  logic               toClear,
  output logic               toStatus,
  output logic               breakPulse
);
  rxw_strobe_t stb;
  logic idleLast;
  logic lowOver;

  uart_rx_watch_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
    .fifoNotEmpty(fifoNotEmpty), .charRcvd(charRcvd), .toMask(toMask),
    .toClear(toClear), .idleLast(idleLast), .lowOver(lowOver),
    .stb(stb), .toStatus(toStatus), .breakPulse(breakPulse)
  );

  uart_rx_watch_dpath #(
    .IDLE_LIMIT(IDLE_LIMIT), .FRAME_W(FRAME_W),
    .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .frameLen(frameLen),
    .idleLast(idleLast), .lowOver(lowOver)
  );
endmodule

// File: rtl/uart_rx_watch_chk.sv
module uart_rx_watch_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic rxLine,
  input logic fifoNotEmpty,
  input logic toMask,
  input logic toClear,
  input logic toStatus,
  input logic breakPulse
);
  AST_TO_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toStatus) |-> $past(bitTick)); // R1
  AST_TO_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !fifoNotEmpty |=> !toStatus); // R2
  AST_TO_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    toClear |=> !toStatus); // R2
  AST_TO_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !toMask |=> !toStatus); // R3
  AST_BRK_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> !$past(rxLine)); // R5
  AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |=> !breakPulse); // R6
endmodule

bind uart_rx_watch uart_rx_watch_chk chk_i (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
  .fifoNotEmpty(fifoNotEmpty), .toMask(toMask), .toClear(toClear),
  .toStatus(toStatus), .breakPulse(breakPulse)
);

// File: tb/uart_rx_watch_tb_top.sv
`timescale 1ns/1ps
module uart_rx_watch_tb_top;
  typedef struct {
    bit    isBrk;
    bit    val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic rxLine = 1'b1;
  logic [3:0] frameLen = 4'd10;
  logic fifoNotEmpty = 1'b0;
  logic charRcvd = 1'b0;
  logic toMask = 1'b0;
  logic toClear = 1'b0;
  logic toStatus;
  logic breakPulse;

  exp_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_watch dut_i (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .rxLine(rxLine),
    .frameLen(frameLen), .fifoNotEmpty(fifoNotEmpty), .charRcvd(charRcvd),
    .toMask(toMask), .toClear(toClear), .toStatus(toStatus),
    .breakPulse(breakPulse)
  );

  // monitor: pops the expected items once outputs have settled
  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0) begin
      exp_t e;
      logic act;
      e = expQ.pop_front();
      act = e.isBrk ? breakPulse : toStatus;
      nChecks++;
      if (act !== e.val) begin
        nFails++;
        $display("FAIL %s: %s actual=%b expected=%b", e.tag,
                 e.isBrk ? "breakPulse" : "toStatus", act, e.val);
      end
    end
  end

  // one cycle of stimulus, then push the expected outputs seen after its edge
  task automatic clk1(input bit tick, input bit expSt, input bit expBrk, input string tag);
    bitTick = tick;
    @(negedge clk);
    bitTick = 1'b0;
    charRcvd = 1'b0;
    toClear = 1'b0;
    expQ.push_back('{1'b0, expSt, tag});
    expQ.push_back('{1'b1, expBrk, tag});
  endtask

  // n ticks, each followed by a gap cycle; status expected high from tick setAt (0 = never)
  task automatic idleRun(input int n, input int setAt, input bit stHeld, input string tag);
    for (int i = 1; i <= n; i++) begin
      bit st;
      st = stHeld || (setAt != 0 && i >= setAt);
      clk1(1'b1, st, 1'b0, tag);
      clk1(1'b0, st, 1'b0, tag);
    end
  endtask

  // n ticks with the line low; pulse expected right after tick pulseAt (0 = never)
  task automatic lowRun(input int n, input int pulseAt, input string tag);
    rxLine = 1'b0;
    for (int i = 1; i <= n; i++) begin
      clk1(1'b1, 1'b0, (i == pulseAt), tag);
      clk1(1'b0, 1'b0, 1'b0, tag);
    end
    rxLine = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (toStatus !== 1'b0 || breakPulse !== 1'b0) begin
      nFails++;
      $display("FAIL R9: reset actual=%b%b expected=00", toStatus, breakPulse);
    end
    rstN = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R9");

    // R1: 32 ticks with data waiting
    toMask = 1'b1; fifoNotEmpty = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R1");
    idleRun(34, 32, 1'b0, "R1");

    // R2: clear strobe, then emptying the FIFO
    toClear = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R2");
    idleRun(32, 32, 1'b0, "R2");
    fifoNotEmpty = 1'b0;
    clk1(1'b1, 1'b0, 1'b0, "R2");
    fifoNotEmpty = 1'b1;
    idleRun(31, 0, 1'b0, "R2");
    toClear = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R2");

    // R4: a character restarts the count
    idleRun(20, 0, 1'b0, "R4");
    charRcvd = 1'b1;
    clk1(1'b0, 1'b0, 1'b0, "R4");
    idleRun(32, 32, 1'b0, "R4");
    charRcvd = 1'b1;
    clk1(1'b1, 1'b1, 1'b0, "R4");
    idleRun(3, 0, 1'b1, "R4");

    // R3: mask low forces status low and freezes the count
    toMask = 1'b0;
    clk1(1'b0, 1'b0, 1'b0, "R3");
    idleRun(40, 0, 1'b0, "R3");
    toMask = 1'b1;
    idleRun(32, 32, 1'b0, "R3");
    toMask = 1'b0;
    clk1(1'b0, 1'b0, 1'b0, "R3");

    // R5/R6: break with frame length 9, then re-armed
    fifoNotEmpty = 1'b0;
    frameLen = 4'd9;
    lowRun(30, 10, "R5");
    lowRun(12, 10, "R6");
    // R8: a short low and a glitched low give nothing
    lowRun(9, 0, "R8");
    lowRun(9, 0, "R8");
    // R7: clamped frame lengths
    frameLen = 4'd3;  lowRun(10, 8, "R7");
    frameLen = 4'd7;  lowRun(10, 8, "R7");
    frameLen = 4'd15; lowRun(15, 13, "R7");
    frameLen = 4'd12; lowRun(15, 13, "R7");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule